// File: doc/BRIEF.md
# Atomic Store Permission Checker

This block decides whether a conditional store (compare-and-swap) may go ahead. The address lookup has already produced a result for the target address. For each request, the block looks at that result: a fault code, read and write permission bits, and a cache-attribute class. It also reads a 6-bit atomic-control register and a flag that says whether a data cache is present. From these it produces a single verdict: pass, or fault with one cause code and the faulting virtual address.

The verdict is registered. It appears one clock after the request strobe, together with a one-cycle done pulse. The fault cause, fault flag and address stay at their last values until the next request. The caller takes the exception when `faultValid` is high in the cycle that `doneValid` pulses.

Top module: `atomic_store_checker`

## Requirements
- R1: While reset is held and directly after it, `doneValid` and `faultValid` are 0, and `faultCause` and `faultVaddr` are 0.
- R2: A request sampled with `reqValid` high at a rising edge gives `doneValid` high for exactly the next cycle. In that cycle `faultVaddr` equals the requested address.
- R3: A nonzero `xlatFault` is reported as the fault cause unchanged.
- R4: If translation succeeds but `permRead` or `permWrite` is 0, the cause is the store-prohibited code (default 29). It is never the load-prohibited code (default 28).
- R5: The cache attribute selects a 2-bit control field. Code 0 (bypass) selects `atomCtl[1:0]`, code 1 (write-through) selects `atomCtl[3:2]` and code 2 (write-back) selects `atomCtl[5:4]`. If the selected field is 00, the result is a fault with the load/store-error code (default 3). Any nonzero field means pass.
- R6: Attribute code 3 (isolate) always faults with the load/store-error code, whatever `atomCtl` holds.
- R7: Attribute codes 4 to 7 never raise an attribute fault.
- R8: With `hasDcache` low, the attribute is treated as bypass (field `atomCtl[1:0]`), whatever `cacheAttr` says.
- R9: Exactly one cause is reported per request. A translation fault wins over a permission fault, and a permission fault wins over an attribute fault. A pass reports cause 0.
- R10: Without a request, `doneValid` stays low and the fault outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Check request strobe |
| reqVaddr | input | 32 | Virtual address of the store |
| xlatFault | input | 6 | Translation fault code, 0 when the lookup succeeded |
| permRead | input | 1 | Page grants read |
| permWrite | input | 1 | Page grants write |
| cacheAttr | input | 3 | Cache-attribute class of the page |
| atomCtl | input | 6 | Atomic-control register |
| hasDcache | input | 1 | Data cache configured |
| doneValid | output | 1 | One-cycle pulse when the verdict is ready |
| faultValid | output | 1 | Verdict is a fault |
| faultCause | output | 6 | Fault cause code, 0 on pass |
| faultVaddr | output | 32 | Address of the checked request |

## Verification
Every result is due exactly one clock after the rising edge that samples `reqValid`. The bench drives inputs on the falling edge and predicts the verdict with its own model. It then compares all four outputs on the next falling edge, which falls after the one register stage the result passes through. Idle cycles are checked the same way: `doneValid` must stay low, and the held outputs must match the model's last verdict.

// File: rtl/atomic_store_checker_pkg.sv
package atomic_store_checker_pkg;
  localparam int CAUSE_W = 6;
  localparam int ATTR_W  = 3;

  typedef enum logic [ATTR_W-1:0] {
    ATTR_BYPASS  = 3'd0,
    ATTR_WRTHRU  = 3'd1,
    ATTR_WRBACK  = 3'd2,
    ATTR_ISOLATE = 3'd3
  } cacheAttrE;

  typedef struct packed {
    logic capture;
    logic done;
  } chkStrobeT;
endpackage

// File: rtl/atomic_store_checker_ctrl.sv
module atomic_store_checker_ctrl
  import atomic_store_checker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output chkStrobeT strobes
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= reqValid;
  end

  always_comb begin
    strobes.capture = reqValid & rstN;
    strobes.done    = doneQ;
  end
endmodule

// File: rtl/atomic_store_checker_dp.sv
module atomic_store_checker_dp
  import atomic_store_checker_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CTL_W         = 6,
  parameter int STORE_PROHIB  = 29,
  parameter int LS_ERROR      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  chkStrobeT          strobes,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic [CAUSE_W-1:0] xlatFault,
  input  logic               permRead,
  input  logic               permWrite,
  input  logic [ATTR_W-1:0]  cacheAttr,
  input  logic [CTL_W-1:0]   atomCtl,
  input  logic               hasDcache,
  output logic               faultValid,
  output logic [CAUSE_W-1:0] faultCause,
  output logic [ADDR_W-1:0]  faultVaddr
);
  localparam int FIELDS = CTL_W / 2;

  logic [ATTR_W-1:0]  effAttr;
  logic [FIELDS-1:0]  fieldSet;
  logic               attrFault;
  logic [CAUSE_W-1:0] nextCause;

  for (genvar f = 0; f < FIELDS; f++) begin : gField
    assign fieldSet[f] = |atomCtl[2*f +: 2];
  end

  always_comb begin
    effAttr   = hasDcache ? cacheAttr : ATTR_BYPASS;
    attrFault = 1'b0;
    case (effAttr)
      ATTR_BYPASS:  attrFault = !fieldSet[0];
      ATTR_WRTHRU:  attrFault = !fieldSet[1];
      ATTR_WRBACK:  attrFault = !fieldSet[2];
      ATTR_ISOLATE: attrFault = 1'b1;
      default:      attrFault = 1'b0;
    endcase

    if (xlatFault != '0)             nextCause = xlatFault;
    else if (!(permRead && permWrite)) nextCause = CAUSE_W'(STORE_PROHIB);
    else if (attrFault)              nextCause = CAUSE_W'(LS_ERROR);
    else                             nextCause = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      faultCause <= '0;
      faultVaddr <= '0;
    end else if (strobes.capture) begin
      faultValid <= (nextCause != '0);
      faultCause <= nextCause;
      faultVaddr <= reqVaddr;
    end
  end
endmodule

// File: rtl/atomic_store_checker.sv
module atomic_store_checker
  import atomic_store_checker_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CTL_W        = 6,
  parameter int STORE_PROHIB = 29,
  parameter int LS_ERROR     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic [CAUSE_W-1:0] xlatFault,
  input  logic               permRead,
  input  logic               permWrite,
  input  logic [ATTR_W-1:0]  cacheAttr,
  input  logic [CTL_W-1:0]   atomCtl,
  input  logic               hasDcache,
  output logic               doneValid,
  output logic               faultValid,
  output logic [CAUSE_W-1:0] faultCause,
  output logic [ADDR_W-1:0]  faultVaddr
);
  chkStrobeT strobes;

  atomic_store_checker_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strobes(strobes)
  );

  atomic_store_checker_dp #(
    .ADDR_W(ADDR_W), .CTL_W(CTL_W),
    .STORE_PROHIB(STORE_PROHIB), .LS_ERROR(LS_ERROR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqVaddr(reqVaddr), .xlatFault(xlatFault),
    .permRead(permRead), .permWrite(permWrite),
    .cacheAttr(cacheAttr), .atomCtl(atomCtl), .hasDcache(hasDcache),
    .faultValid(faultValid), .faultCause(faultCause), .faultVaddr(faultVaddr)
  );

  assign doneValid = strobes.done;
endmodule

// File: rtl/atomic_store_checker_sva.sv
module atomic_store_checker_sva
  import atomic_store_checker_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CTL_W        = 6,
  parameter int STORE_PROHIB = 29,
  parameter int LS_ERROR     = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqVaddr,
  input logic [CAUSE_W-1:0] xlatFault,
  input logic               permRead,
  input logic               permWrite,
  input logic [ATTR_W-1:0]  cacheAttr,
  input logic [CTL_W-1:0]   atomCtl,
  input logic               hasDcache,
  input logic               doneValid,
  input logic               faultValid,
  input logic [CAUSE_W-1:0] faultCause,
  input logic [ADDR_W-1:0]  faultVaddr
);
  a_r2_done_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (doneValid && faultVaddr == $past(reqVaddr)));

  a_r3_xlat_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault != '0) |=> (faultValid && faultCause == $past(xlatFault)));

  a_r4_perm_store_prohib: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault == '0 && !(permRead && permWrite))
      |=> (faultCause == CAUSE_W'(STORE_PROHIB)));

  a_r6_isolate_faults: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault == '0 && permRead && permWrite && hasDcache
      && cacheAttr == ATTR_ISOLATE) |=> (faultCause == CAUSE_W'(LS_ERROR)));

  a_r8_nocache_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault == '0 && permRead && permWrite && !hasDcache)
      |=> (faultValid == (atomCtl[1:0] == 2'b00)));

  a_r9_cause_iff_fault: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (faultValid == (faultCause != '0)));

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!doneValid && $stable(faultCause) && $stable(faultVaddr)
                   && $stable(faultValid)));
endmodule

bind atomic_store_checker atomic_store_checker_sva #(
  .ADDR_W(ADDR_W), .CTL_W(CTL_W),
  .STORE_PROHIB(STORE_PROHIB), .LS_ERROR(LS_ERROR)
) sva_i (.*);

// File: tb/atomic_store_checker_tb_top.sv
module atomic_store_checker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [5:0]  xlatFault = '0;
  logic        permRead = 1'b0;
  logic        permWrite = 1'b0;
  logic [2:0]  cacheAttr = '0;
  logic [5:0]  atomCtl = '0;
  logic        hasDcache = 1'b0;
  logic        doneValid, faultValid;
  logic [5:0]  faultCause;
  logic [31:0] faultVaddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [5:0]  expCause = '0;
  logic [31:0] expVaddr = '0;

  always #4 clk = ~clk;

  atomic_store_checker dut_i (.*);

  function automatic logic [5:0] model(input logic [5:0] xf, input logic r,
      input logic w, input logic [2:0] at, input logic [5:0] ctl, input logic dc);
    int a;
    a = dc ? int'(at) : 0;
    if (xf != 0) return xf;
    if (!(r && w)) return 6'd29;
    if (a == 3) return 6'd3;
    if (a <= 2 && ((ctl >> (2*a)) & 6'd3) == 0) return 6'd3;
    return 6'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [31:0] va,
      input logic [5:0] xf, input logic r, input logic w, input logic [2:0] at,
      input logic [5:0] ctl, input logic dc);
    @(negedge clk);
    reqValid = v; reqVaddr = va; xlatFault = xf; permRead = r; permWrite = w;
    cacheAttr = at; atomCtl = ctl; hasDcache = dc;
    if (v) begin
      expCause = model(xf, r, w, at, ctl, dc);
      expVaddr = va;
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, "done", {31'd0, doneValid}, {31'd0, v});
    check(tag, "fault", {31'd0, faultValid}, {31'd0, expCause != 0});
    check(tag, "cause", {26'd0, faultCause}, {26'd0, expCause});
    check(tag, "vaddr", faultVaddr, expVaddr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", {31'd0, doneValid}, 32'd0);
    check("R1", "fault", {31'd0, faultValid}, 32'd0);
    check("R1", "cause", {26'd0, faultCause}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "vaddr", faultVaddr, 32'd0);
    // R2 basic pass, R3 translation fault
    step("R2", 1, 32'h1000_0040, 0, 1, 1, 3'd7, 6'h00, 1);
    step("R3", 1, 32'h2000_0000, 6'd24, 1, 1, 3'd0, 6'h3f, 1);
    // R4 missing permissions
    step("R4", 1, 32'h3000_0004, 0, 1, 0, 3'd0, 6'h3f, 1);
    step("R4", 1, 32'h3000_0008, 0, 0, 1, 3'd0, 6'h3f, 1);
    // R5 field selection, each attribute with zero and nonzero fields
    for (int a = 0; a < 3; a++) begin
      for (int c = 0; c < 64; c += 7) begin
        step("R5", 1, 32'h4000_0000 + c, 0, 1, 1, 3'(a), 6'(c), 1);
      end
    end
    // R6 isolate always faults
    step("R6", 1, 32'h5000_0000, 0, 1, 1, 3'd3, 6'h3f, 1);
    // R7 other classes never fault
    for (int a = 4; a < 8; a++) step("R7", 1, 32'h6000_0000 + a, 0, 1, 1, 3'(a), 6'h00, 1);
    // R8 no data cache forces bypass
    step("R8", 1, 32'h7000_0000, 0, 1, 1, 3'd3, 6'h01, 0);
    step("R8", 1, 32'h7000_0004, 0, 1, 1, 3'd2, 6'h30, 0);
    // R9 priority
    step("R9", 1, 32'h8000_0000, 6'd16, 0, 0, 3'd3, 6'h00, 1);
    step("R9", 1, 32'h8000_0004, 0, 0, 1, 3'd3, 6'h00, 1);
    // R10 idle holds
    step("R10", 0, 32'hdead_beef, 6'd5, 1, 1, 3'd0, 6'h00, 1);
    step("R10", 0, 32'h0, 0, 1, 1, 3'd0, 6'h3f, 1);
    step("R2", 1, 32'h9000_0000, 0, 1, 1, 3'd1, 6'h04, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule